// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Fence and Atomic Swap

This block sits between the memory port of a simple in-order core and a single-ported data cache. Retired stores are parked in a small in-order queue and written to the cache one at a time, oldest first. Stores stay hidden from other agents until they reach the cache, but they also stop holding up the core. A load may use the cache port ahead of stores that are still waiting. If a waiting store holds the same word, the load takes its value from the youngest such store instead of reading the cache.

A fence is accepted only once every parked store has reached the cache. An atomic swap is a full barrier. It waits for the queue to empty and is then sent to the cache as one indivisible read-and-write that returns the old value. Every accepted load, fence and swap gets exactly one response, one cycle after acceptance. The cache is expected to return read data the cycle after it accepts a read or swap. Accesses are whole aligned words, so addresses are compared in full.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty, `core_rsp_valid` is 0 and `cache_valid` is 0. With no accepted request, no response appears. With an empty queue and no core claim, the cache port stays idle.
- R2: A store (`core_op` = 01) is accepted whenever the queue is not full. It never produces a response and does not reach the cache in its acceptance cycle.
- R3: When the queue holds DEPTH stores, `core_ready` is 0 for a store.
- R4: Parked stores are presented as cache writes (`cache_op` = 01) strictly oldest first, carrying their own address and data. At most one store leaves per cycle, and only when `cache_ready` is 1.
- R5: A load (`core_op` = 00) that matches no parked store takes the cache port as a read (`cache_op` = 00), ahead of any waiting store. When `cache_ready` is 1 it is accepted, and its response carries `cache_rdata` in the next cycle.
- R6: A load that matches one or more parked stores is accepted whatever the state of `cache_ready`. It does not read the cache, and its response next cycle carries the data of the youngest matching store.
- R7: A fence (`core_op` = 10) is ready only when the queue is empty. Its response follows one cycle after acceptance, with data 0.
- R8: An atomic swap (`core_op` = 11) waits until the queue is empty and `cache_ready` is 1. It is then issued as `cache_op` = 11 with the core's address and data, and its response next cycle carries the old word.
- R9: While `cache_ready` is 0, no store drains and a load that matches no parked store is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Request accepted this cycle |
| core_op | input | 2 | 00 load, 01 store, 10 fence, 11 atomic swap |
| core_addr | input | AW | Word address |
| core_wdata | input | DW | Store or swap data |
| core_rsp_valid | output | 1 | Response for a load, fence or swap |
| core_rsp_data | output | DW | Load value, old swap value, or 0 for a fence |
| cache_valid | output | 1 | Cache request present |
| cache_ready | input | 1 | Cache accepts the request |
| cache_op | output | 2 | 00 read, 01 write, 11 swap |
| cache_addr | output | AW | Cache word address |
| cache_wdata | output | DW | Write or swap data |
| cache_rdata | input | DW | Read data, valid the cycle after an accepted read or swap |

## Verification
Two kinds of same-cycle overlap matter. A load can forward from a store in the same cycle that the store is leaving for the cache. A load can also take the cache port in a cycle where a parked store is waiting to drain. The bench provokes both by filling the queue while `cache_ready` is low and then issuing loads, first to matching and then to non-matching addresses, while `cache_ready` is high or toggling at random. A behavioural model built from a queue and a word array predicts, every clock, which request owns the cache port, which store is at the head, and the data each response carries. The bench flags any cycle where a write is presented out of order, or where a load is served from the wrong source.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FENCE = 2'b10,
    OP_SWAP  = 2'b11
  } core_op_e;

  localparam logic [1:0] C_READ  = 2'b00;
  localparam logic [1:0] C_WRITE = 2'b01;
  localparam logic [1:0] C_SWAP  = 2'b11;

  // slot holding the k-th oldest entry of a circular queue
  function automatic int age_slot(int head, int k, int depth);
    return (head + k) % depth;
  endfunction

  // next pointer value with wrap
  function automatic int bump(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [AW-1:0] ord_addr [DEPTH],
  output logic [DW-1:0] ord_data [DEPTH],
  output logic          ord_live [DEPTH]
);
  import tsb_pkg::*;

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] head, tail;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[tail] <= push_addr;
      data_mem[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= PW'(bump(int'(tail), DEPTH));
      if (pop)  head <= PW'(bump(int'(head), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // entries presented oldest (k = 0) to youngest
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW-1:0] slot;
    assign slot        = PW'(age_slot(int'(head), k, DEPTH));
    assign ord_addr[k] = addr_mem[slot];
    assign ord_data[k] = data_mem[slot];
    assign ord_live[k] = (count > CW'(k));
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/tsb_forward.sv
module tsb_forward #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ord_addr [DEPTH],
  input  logic [DW-1:0] ord_data [DEPTH],
  input  logic          ord_live [DEPTH],
  output logic          hit,
  output logic [DW-1:0] data
);
  // later (younger) matches override earlier ones
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ord_live[k] && (ord_addr[k] == ld_addr)) begin
        hit  = 1'b1;
        data = ord_data[k];
      end
    end
  end
endmodule

// File: rtl/tsb_port_arb.sv
module tsb_port_arb #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          core_claim,
  input  logic          core_swap,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          drain_pending,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          cache_ready,
  output logic          cache_valid,
  output logic [1:0]    cache_op,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata,
  output logic          core_go,
  output logic          drain_go
);
  import tsb_pkg::*;

  always_comb begin
    cache_valid = 1'b0;
    cache_op    = C_READ;
    cache_addr  = '0;
    cache_wdata = '0;
    if (core_claim) begin
      cache_valid = 1'b1;
      cache_op    = core_swap ? C_SWAP : C_READ;
      cache_addr  = core_addr;
      cache_wdata = core_swap ? core_wdata : '0;
    end else if (drain_pending) begin
      cache_valid = 1'b1;
      cache_op    = C_WRITE;
      cache_addr  = head_addr;
      cache_wdata = head_data;
    end
  end

  assign core_go  = core_claim & cache_ready;
  assign drain_go = ~core_claim & drain_pending & cache_ready;
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_valid,
  output logic          core_ready,
  input  logic [1:0]    core_op,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_rsp_valid,
  output logic [DW-1:0] core_rsp_data,
  output logic          cache_valid,
  input  logic          cache_ready,
  output logic [1:0]    cache_op,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata,
  input  logic [DW-1:0] cache_rdata
);
  import tsb_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  core_op_e      op;
  logic          is_ld, is_st, is_fe, is_at;
  logic [CW-1:0] count;
  logic          buf_empty, buf_full;
  logic [AW-1:0] ord_addr [DEPTH];
  logic [DW-1:0] ord_data [DEPTH];
  logic          ord_live [DEPTH];
  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  logic          core_claim, core_go, drain_go, push;
  logic          fwd_q, fence_q, pend_q;
  logic [DW-1:0] fwd_data_q;

  assign op    = core_op_e'(core_op);
  assign is_ld = (op == OP_LOAD);
  assign is_st = (op == OP_STORE);
  assign is_fe = (op == OP_FENCE);
  assign is_at = (op == OP_SWAP);

  assign buf_empty = (count == '0);
  assign buf_full  = (count == CW'(DEPTH));

  tsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_addr(core_addr),
    .push_data(core_wdata),
    .pop      (drain_go),
    .count    (count),
    .ord_addr (ord_addr),
    .ord_data (ord_data),
    .ord_live (ord_live)
  );

  tsb_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .ld_addr (core_addr),
    .ord_addr(ord_addr),
    .ord_data(ord_data),
    .ord_live(ord_live),
    .hit     (fwd_hit),
    .data    (fwd_data)
  );

  // core wants the cache port: unmatched load, or swap once drained
  assign core_claim = core_valid & ((is_ld & ~fwd_hit) | (is_at & buf_empty));

  tsb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .core_claim   (core_claim),
    .core_swap    (is_at),
    .core_addr    (core_addr),
    .core_wdata   (core_wdata),
    .drain_pending(~buf_empty),
    .head_addr    (ord_addr[0]),
    .head_data    (ord_data[0]),
    .cache_ready  (cache_ready),
    .cache_valid  (cache_valid),
    .cache_op     (cache_op),
    .cache_addr   (cache_addr),
    .cache_wdata  (cache_wdata),
    .core_go      (core_go),
    .drain_go     (drain_go)
  );

  always_comb begin
    unique case (op)
      OP_STORE: core_ready = ~buf_full;
      OP_LOAD:  core_ready = fwd_hit | cache_ready;
      OP_FENCE: core_ready = buf_empty;
      default:  core_ready = buf_empty & cache_ready;
    endcase
  end

  assign push = core_valid & is_st & ~buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q      <= 1'b0;
      fence_q    <= 1'b0;
      pend_q     <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      fwd_q      <= core_valid & is_ld & fwd_hit;
      fwd_data_q <= fwd_data;
      fence_q    <= core_valid & is_fe & buf_empty;
      pend_q     <= core_go;
    end
  end

  assign core_rsp_valid = fwd_q | fence_q | pend_q;
  assign core_rsp_data  = pend_q ? cache_rdata : (fwd_q ? fwd_data_q : '0);

  assert_fence_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && is_fe && core_ready) |-> (count == '0));

  assert_swap_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && cache_op == C_SWAP) |-> (count == '0));

  assert_fwd_no_cache_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && is_ld && fwd_hit) |-> !(cache_valid && cache_op == C_READ));

  assert_load_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && is_ld && core_ready) |=> core_rsp_valid);

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !(core_valid && is_st && core_ready));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_ready && !(core_valid && is_st)) |=> (count == $past(count)));

endmodule

// File: tb/tso_store_buffer_test.sv
module tso_store_buffer_test;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10, AT = 2'b11;
  localparam logic [1:0] CRD = 2'b00, CWR = 2'b01, CSW = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          core_valid;
  logic          core_ready;
  logic [1:0]    core_op;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_wdata;
  logic          core_rsp_valid;
  logic [DW-1:0] core_rsp_data;
  logic          cache_valid;
  logic          cache_ready;
  logic [1:0]    cache_op;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_wdata;
  logic [DW-1:0] cache_rdata;

  always #10 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
    .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
    .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_op(cache_op),
    .cache_addr(cache_addr), .cache_wdata(cache_wdata), .cache_rdata(cache_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  int          qa[$];
  logic [31:0] qd[$];
  logic [31:0] mem [16];
  logic        erv = 1'b0;
  logic [31:0] erd = '0;
  string       rtag = "R1";
  bit          last_acc;

  logic          v;
  logic [1:0]    o;
  logic [AW-1:0] a;
  logic [DW-1:0] d;
  logic          cr;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit          hit, empty, full, erdy, claim, ev;
    logic [31:0] hd, ed;
    logic [1:0]  eop;
    int          ea;
    string       t;
    @(negedge clk);
    core_valid = v; core_op = o; core_addr = a; core_wdata = d; cache_ready = cr;
    #5;
    hit = 0; hd = '0;
    for (int i = qa.size() - 1; i >= 0; i--)
      if (!hit && qa[i] == int'(a)) begin hit = 1; hd = qd[i]; end
    empty = (qa.size() == 0);
    full  = (qa.size() == DEPTH);
    case (o)
      ST: begin erdy = !full;         t = "R3"; end
      LD: begin erdy = hit || cr;     t = (!hit && !cr) ? "R9" : "R5"; end
      FE: begin erdy = empty;         t = "R7"; end
      default: begin erdy = empty && cr; t = "R8"; end
    endcase
    if (v) chk(core_ready === erdy, t, 32'(core_ready), 32'(erdy));
    claim = v && ((o == LD && !hit) || (o == AT && empty));
    ev = 1; ea = 0; ed = '0; eop = CRD;
    if (claim) begin
      eop = (o == AT) ? CSW : CRD; ea = int'(a); ed = (o == AT) ? d : '0;
      t = (o == AT) ? "R8" : "R5";
    end else if (!empty) begin
      eop = CWR; ea = qa[0]; ed = qd[0]; t = "R4";
    end else begin
      ev = 0; t = (v && o == ST) ? "R2" : "R1";
    end
    chk(cache_valid === ev, t, 32'(cache_valid), 32'(ev));
    if (ev) begin
      chk(cache_op === eop, t, 32'(cache_op), 32'(eop));
      chk(cache_addr === AW'(ea), t, 32'(cache_addr), 32'(ea));
      if (eop != CRD) chk(cache_wdata === ed, t, cache_wdata, ed);
    end
    chk(core_rsp_valid === erv, rtag, 32'(core_rsp_valid), 32'(erv));
    if (erv) chk(core_rsp_data === erd, rtag, core_rsp_data, erd);
    last_acc = v && erdy;
    @(posedge clk);
    #1;
    if (ev && cr) begin
      case (eop)
        CRD: cache_rdata = mem[ea % 16];
        CWR: mem[ea % 16] = ed;
        default: begin cache_rdata = mem[ea % 16]; mem[ea % 16] = ed; end
      endcase
      if (eop == CWR) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    end
    erv = 0; erd = '0; rtag = "R1";
    if (last_acc) begin
      case (o)
        ST: begin qa.push_back(int'(a)); qd.push_back(d); rtag = "R2"; end
        LD: begin erv = 1; erd = hit ? hd : cache_rdata; rtag = hit ? "R6" : "R5"; end
        FE: begin erv = 1; erd = '0; rtag = "R7"; end
        default: begin erv = 1; erd = cache_rdata; rtag = "R8"; end
      endcase
    end
  endtask

  task automatic issue(logic [1:0] op, int addr, logic [31:0] data, logic rdy);
    for (int n = 0; n < 40; n++) begin
      v = 1; o = op; a = AW'(addr); d = data; cr = rdy;
      step();
      if (last_acc) break;
    end
    v = 0;
  endtask

  task automatic idle(int n, logic rdy);
    for (int i = 0; i < n; i++) begin
      v = 0; cr = rdy; step();
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i * 17);
    cache_rdata = '0;
    rst_n = 0; core_valid = 0; core_op = LD; core_addr = '0; core_wdata = '0; cache_ready = 0;
    v = 0; o = LD; a = '0; d = '0; cr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #5;
    chk(core_rsp_valid === 1'b0, "R1", 32'(core_rsp_valid), 0);
    chk(cache_valid === 1'b0, "R1", 32'(cache_valid), 0);
    idle(2, 1);

    // fill while the cache stalls (R2, R3)
    issue(ST, 1, 32'hAAAA_0001, 0);
    issue(ST, 2, 32'hAAAA_0002, 0);
    issue(ST, 1, 32'hAAAA_0003, 0);
    issue(ST, 3, 32'hAAAA_0004, 0);
    v = 1; o = ST; a = 16'd4; d = 32'hBAD0_0000; cr = 0; step();   // R3 full
    v = 0;
    // forward youngest while stalled (R6), unmatched load stalls (R9)
    issue(LD, 1, 0, 0);
    v = 1; o = LD; a = 16'd5; d = '0; cr = 0; step();               // R9
    v = 1; o = FE; a = '0; cr = 0; step();                          // R7 not ready
    v = 0;
    // unmatched load bypasses pending drain (R5), then drain order (R4)
    issue(LD, 5, 0, 1);
    issue(LD, 2, 0, 1);
    idle(1, 1);
    issue(LD, 1, 0, 1);
    idle(4, 1);
    issue(FE, 0, 0, 1);
    idle(1, 1);
    // atomic waits for drain (R8)
    issue(ST, 6, 32'hCCCC_0006, 0);
    issue(ST, 7, 32'hCCCC_0007, 0);
    issue(AT, 6, 32'hDDDD_0006, 1);
    idle(1, 1);
    issue(AT, 9, 32'hDDDD_0009, 1);
    idle(1, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 100);
      v  = ($urandom % 4) != 0;
      o  = (r < 35) ? LD : (r < 75) ? ST : (r < 85) ? FE : AT;
      a  = AW'($urandom % 8);
      d  = $urandom;
      cr = ($urandom % 4) != 0;
      step();
    end
    v = 0;
    issue(FE, 0, 0, 1);
    idle(1, 1);
    for (int k = 0; k < 8; k++) begin
      issue(LD, k, 0, 1);
    end
    idle(2, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule